// File: doc/BRIEF.md
# Burst column address sequencer

This block turns a single read or write command into a stream of column addresses, one per clock, for a synchronous DRAM column path. When a command arrives it captures the starting column, the command direction and the programmed mode word. From the clock edge after the command, it presents one column address per cycle until the burst ends. Each address comes with a valid flag, and a last-beat flag marks the final beat of a bounded burst. Moving data and aligning to read latency belong to other blocks.

The mode word picks how many beats a burst has and in what order the columns come. Sequential order counts upward inside an aligned block the size of the burst and wraps within that block. Interleaved order XORs the start column with the beat index. Full-page mode runs on through every column of the row and keeps wrapping until something stops it. A separate mode bit turns writes into single-beat accesses while reads keep the programmed length. A running burst ends early when the stop input is asserted. It is replaced when a new command arrives, and the new burst's first address appears on the next cycle. The block has a small state machine with three states. IDLE means no burst is in progress. FIXED is a bounded burst that counts toward its last beat. PAGE is an unbounded full-page burst. The transitions between them are:
- Start: IDLE to FIXED or IDLE to PAGE, on a command.
- Finish: FIXED to IDLE, after the last beat.
- Halt: FIXED or PAGE to IDLE, on stop.
- Restart: FIXED or PAGE back to FIXED or PAGE, on a new command.

Top module: `burst_col_seq`

## Requirements
- R1: Mode word bits [2:0] set the burst length. Code 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `col_last` is high on the final beat only, and `col_valid` drops on the cycle after that beat unless a new command arrives.
- R2: When mode bit [3] is 0 (sequential), beat k carries the start column with its low log2(length) bits replaced by (start + k) modulo the length. For example, length 4 from start 2 gives 2, 3, 0, 1.
- R3: When mode bit [3] is 1 (interleaved), beat k carries the start column XOR k. For example, length 8 from start 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R4: Code 111 with bit [3] = 0 is full page. Beat k is (start + k) modulo 2^COL_W, the burst keeps wrapping past the end of the row, and `col_last` is never asserted.
- R5: Codes 100, 101 and 110, and code 111 with bit [3] = 1, run as length 1. `mode_err` follows the current `mode_word` combinationally and is high for exactly these settings.
- R6: When mode bit [9] is 1, write commands produce a single beat, while read commands keep the programmed length and order.
- R7: While a burst is running and no command is present, `burst_stop` ends it, so `col_valid` is low on the next cycle. When the block is idle, `burst_stop` has no effect.
- R8: A command arriving during a burst ends that burst, and the next cycle shows beat 0 of the new burst. When `cmd_valid` and `burst_stop` arrive together, the command wins.
- R9: After reset `col_valid` and `col_last` are low. Beat 0 appears on the cycle after the command, and each later beat follows one cycle after the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_word | input | 12 | Programmed mode: [2:0] length code, [3] order, [9] single-beat writes |
| cmd_valid | input | 1 | Read or write command this cycle |
| cmd_is_write | input | 1 | 1 when the command is a write |
| cmd_col | input | COL_W | Starting column of the command |
| burst_stop | input | 1 | Ends the running burst |
| col_addr | output | COL_W | Current column address |
| col_valid | output | 1 | `col_addr` holds a burst beat |
| col_last | output | 1 | Final beat of a bounded burst |
| mode_err | output | 1 | Current mode word selects a reserved length setting |

## Verification
The bench builds the block with the default 9-bit column. With that width a full-page burst is only 512 beats long, so the bench can watch one run through every column of the row, see it wrap past the row end, and still have time for many random bursts. The random bursts draw whole 12-bit mode words, so reserved codes, interleaved full-page requests and the single-beat write bit all occur naturally. Directed cases cover the two worked orderings, a stop in the middle of a burst, a stop while idle, a command in the middle of a burst, and a command and stop arriving in the same cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int MODE_W   = 12;
    localparam int LEN_LSB  = 0;
    localparam int ORDER_B  = 3;
    localparam int WSINGLE_B = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        LC_ONE   = 3'b000,
        LC_TWO   = 3'b001,
        LC_FOUR  = 3'b010,
        LC_EIGHT = 3'b011,
        LC_PAGE  = 3'b111
    } len_code_e;
endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [MODE_W-1:0] mode_word,
    input  logic              is_write,
    output logic [COL_W-1:0]  len_mask,
    output logic              full_page,
    output logic              interleave,
    output logic              reserved
);
    logic [2:0]       code;
    logic             ord;
    logic [COL_W-1:0] raw_mask;
    logic             raw_full;

    assign code = mode_word[LEN_LSB +: 3];
    assign ord  = mode_word[ORDER_B];

    always_comb begin
        raw_mask = '0;
        raw_full = 1'b0;
        reserved = 1'b0;
        unique case (code)
            LC_ONE:   raw_mask = '0;
            LC_TWO:   raw_mask = COL_W'(1);
            LC_FOUR:  raw_mask = COL_W'(3);
            LC_EIGHT: raw_mask = COL_W'(7);
            LC_PAGE: begin
                if (ord) begin
                    reserved = 1'b1;
                end else begin
                    raw_mask = '1;
                    raw_full = 1'b1;
                end
            end
            default:  reserved = 1'b1;
        endcase
    end

    always_comb begin
        if (is_write && mode_word[WSINGLE_B]) begin
            len_mask  = '0;
            full_page = 1'b0;
        end else begin
            len_mask  = raw_mask;
            full_page = raw_full;
        end
    end

    assign interleave = ord & ~raw_full;
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] len_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] wrap_sum;
    logic [COL_W-1:0] flip;

    assign wrap_sum = start_col + beat;
    assign flip     = start_col ^ beat;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!len_mask[b])
                addr[b] = start_col[b];
            else if (interleave)
                addr[b] = flip[b];
            else
                addr[b] = wrap_sum[b];
        end
    end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             burst_stop,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [COL_W-1:0] dec_mask,
    input  logic             dec_full,
    input  logic             dec_ilv,
    output logic [COL_W-1:0] start_q,
    output logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] mask_q,
    output logic             ilv_q,
    output logic             valid,
    output logic             last
);
    seq_state_e state, state_nx;
    logic       at_end;

    assign at_end = (beat_q == mask_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) state_nx = dec_full ? ST_PAGE : ST_FIXED;
            end
            ST_FIXED: begin
                if (cmd_valid)       state_nx = dec_full ? ST_PAGE : ST_FIXED;
                else if (burst_stop) state_nx = ST_IDLE;
                else if (at_end)     state_nx = ST_IDLE;
            end
            ST_PAGE: begin
                if (cmd_valid)       state_nx = dec_full ? ST_PAGE : ST_FIXED;
                else if (burst_stop) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else if (cmd_valid) begin
            start_q <= cmd_col;
            beat_q  <= '0;
            mask_q  <= dec_mask;
            ilv_q   <= dec_ilv;
        end else if (state != ST_IDLE) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    always_comb begin
        valid = (state != ST_IDLE);
        last  = (state == ST_FIXED) && at_end;
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_valid,
    input  logic              cmd_is_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              burst_stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last,
    output logic              mode_err
);
    logic [COL_W-1:0] dec_mask, start_q, beat_q, mask_q;
    logic             dec_full, dec_ilv, ilv_q;

    bcs_mode_decode #(.COL_W(COL_W)) u_dec (
        .mode_word (mode_word),
        .is_write  (cmd_is_write),
        .len_mask  (dec_mask),
        .full_page (dec_full),
        .interleave(dec_ilv),
        .reserved  (mode_err)
    );

    bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .burst_stop(burst_stop),
        .cmd_col   (cmd_col),
        .dec_mask  (dec_mask),
        .dec_full  (dec_full),
        .dec_ilv   (dec_ilv),
        .start_q   (start_q),
        .beat_q    (beat_q),
        .mask_q    (mask_q),
        .ilv_q     (ilv_q),
        .valid     (col_valid),
        .last      (col_last)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .start_col (start_q),
        .beat      (beat_q),
        .len_mask  (mask_q),
        .interleave(ilv_q),
        .addr      (col_addr)
    );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             burst_stop,
    input logic [COL_W-1:0] cmd_col,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_last
);
    assert_last_has_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    assert_last_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_valid) |=> !col_valid);

    assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !cmd_valid) |=> !col_valid);

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_valid && !cmd_valid) |=> !col_valid);

    assert_cmd_first_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

    assert_beats_continue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !cmd_valid && !burst_stop) |=> col_valid);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .burst_stop(burst_stop),
    .cmd_col   (cmd_col),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .col_last  (col_last)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;
    localparam int COL_W = 9;
    localparam int ROW   = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [11:0]      mode_word = '0;
    logic             cmd_valid = 1'b0;
    logic             cmd_is_write = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             burst_stop = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid, col_last, mode_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .cmd_valid(cmd_valid),
        .cmd_is_write(cmd_is_write), .cmd_col(cmd_col), .burst_stop(burst_stop),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
        .mode_err(mode_err)
    );

    function automatic bit m_full(logic [11:0] m, bit wr);
        return !(wr && m[9]) && m[2:0] == 3'b111 && !m[3];
    endfunction

    function automatic int m_mask(logic [11:0] m, bit wr);
        if (wr && m[9]) return 0;
        case (m[2:0])
            3'b001: return 1;
            3'b010: return 3;
            3'b011: return 7;
            3'b111: return m[3] ? 0 : ROW - 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_err(logic [11:0] m);
        return (m[2:0] inside {3'b100, 3'b101, 3'b110}) || (m[2:0] == 3'b111 && m[3]);
    endfunction

    function automatic int beat_addr(logic [11:0] m, bit wr, int s, int k);
        int msk;
        msk = m_mask(m, wr);
        if (m_full(m, wr)) return (s + k) % ROW;
        if (m[3]) return s ^ k;
        return (s & ~msk) | ((s + k) & msk);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(logic [11:0] m, bit wr, int s, bit st);
        @(negedge clk);
        mode_word = m; cmd_is_write = wr; cmd_col = COL_W'(s);
        cmd_valid = 1'b1; burst_stop = st;
        #0.5;
        chk("R5 mode_err", int'(mode_err), int'(m_err(m)));
        @(negedge clk);
        cmd_valid = 1'b0; burst_stop = 1'b0;
    endtask

    task automatic beats(string req, logic [11:0] m, bit wr, int s, int n);
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            chk({req, " valid"}, int'(col_valid), 1);
            chk({req, " addr"}, int'(col_addr), beat_addr(m, wr, s, k));
            chk({req, " last"}, int'(col_last),
                int'(!m_full(m, wr) && k == m_mask(m, wr)));
        end
    endtask

    task automatic idle_next(string req);
        @(negedge clk);
        chk({req, " idle"}, int'(col_valid), 0);
    endtask

    task automatic stop_now(string req);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        chk({req, " stopped"}, int'(col_valid), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset valid", int'(col_valid), 0);
        chk("R9 reset last", int'(col_last), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: length 4 sequential from 2 -> 2,3,0,1
        issue(12'h002, 1'b0, 2, 1'b0);
        beats("R2 seq4", 12'h002, 1'b0, 2, 4);
        idle_next("R1 seq4");

        // R3: length 8 interleaved from 5
        issue(12'h00B, 1'b0, 5, 1'b0);
        beats("R3 ilv8", 12'h00B, 1'b0, 5, 8);
        idle_next("R1 ilv8");

        // R1: every bounded length, sequential from an odd start
        for (int c = 0; c < 4; c++) begin
            issue(12'(c), 1'b0, 13, 1'b0);
            beats("R1 len", 12'(c), 1'b0, 13, m_mask(12'(c), 1'b0) + 1);
            idle_next("R1 len");
        end

        // R4: full page runs past the row end, then is stopped
        issue(12'h007, 1'b0, 300, 1'b0);
        beats("R4 page", 12'h007, 1'b0, 300, ROW + 6);
        stop_now("R4 page");

        // R5: reserved codes and interleaved full page act as one beat
        issue(12'h005, 1'b0, 77, 1'b0);
        beats("R5 rsv", 12'h005, 1'b0, 77, 1);
        idle_next("R5 rsv");
        issue(12'h00F, 1'b0, 40, 1'b0);
        beats("R5 ilvpage", 12'h00F, 1'b0, 40, 1);
        idle_next("R5 ilvpage");

        // R6: single-beat writes, reads keep length
        issue(12'h203, 1'b1, 21, 1'b0);
        beats("R6 write", 12'h203, 1'b1, 21, 1);
        idle_next("R6 write");
        issue(12'h203, 1'b0, 21, 1'b0);
        beats("R6 read", 12'h203, 1'b0, 21, 8);
        idle_next("R6 read");

        // R7: stop mid-burst, and stop while idle has no effect
        issue(12'h003, 1'b0, 9, 1'b0);
        beats("R7 mid", 12'h003, 1'b0, 9, 3);
        stop_now("R7 mid");
        stop_now("R7 idle");
        issue(12'h001, 1'b0, 6, 1'b0);
        beats("R7 after", 12'h001, 1'b0, 6, 2);
        idle_next("R7 after");

        // R8: new command interrupts; command beats simultaneous stop
        issue(12'h003, 1'b0, 3, 1'b0);
        beats("R8 old", 12'h003, 1'b0, 3, 3);
        issue(12'h00A, 1'b0, 26, 1'b0);
        beats("R8 new", 12'h00A, 1'b0, 26, 4);
        idle_next("R8 new");
        issue(12'h002, 1'b1, 50, 1'b1);
        beats("R8 cmd+stop", 12'h002, 1'b1, 50, 4);
        idle_next("R8 cmd+stop");

        // random bursts
        for (int i = 0; i < 80; i++) begin
            logic [11:0] m;
            bit          wr;
            int          s;
            m  = 12'($urandom);
            wr = 1'($urandom);
            s  = int'($urandom_range(ROW - 1, 0));
            issue(m, wr, s, 1'b0);
            if (m_full(m, wr)) begin
                beats("R4 rand", m, wr, s, 20);
                stop_now("R7 rand");
            end else begin
                beats("R9 rand", m, wr, s, m_mask(m, wr) + 1);
                idle_next("R1 rand");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule